// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when an analog-to-digital conversion engine begins each conversion sequence. It can ignore the external trigger and run from a software start pulse, either once or in repeated back-to-back sequences. It can also pick one of several candidate trigger inputs and start from that input, either on an edge or while a level is held, with the polarity set by configuration. The selected trigger is passed through a two-flop synchronizer before any edge or level is judged.

The conversion engine raises a one-cycle done pulse when a sequence ends. The block returns a one-cycle start pulse and a busy signal. The busy signal also serves as the converter's digital clock enable, so the engine is clocked only while a sequence is in progress. In edge modes, an active edge that arrives while a sequence is in progress sets a sticky overrun flag and does not start a sequence. Software clears that flag by writing 1.

Top module: `adc_trig_seq`

## Requirements
- R1: With `cfg_trig_en`=0 and `cfg_scan`=0 (single mode), a `sw_start` pulse while idle gives exactly one `seq_start`. Trigger activity and `sw_start` pulses while busy are ignored.
- R2: With `cfg_trig_en`=0 and `cfg_scan`=1 (continuous mode), a `sw_start` pulse starts sequences that repeat, each new one starting in the cycle the previous one reports done. After `cfg_scan` drops, the sequence in progress finishes and no new one starts.
- R3: With `cfg_trig_en`=1, `cfg_level`=0 and `cfg_pol`=0, each falling edge of the selected trigger while idle starts exactly one sequence, and rising edges start none.
- R4: With `cfg_trig_en`=1, `cfg_level`=0 and `cfg_pol`=1, each rising edge while idle starts exactly one sequence, and falling edges start none.
- R5: With `cfg_trig_en`=1, `cfg_level`=1 and `cfg_pol`=0, sequences start repeatedly for as long as the synchronized trigger stays low.
- R6: With `cfg_trig_en`=1, `cfg_level`=1 and `cfg_pol`=1, sequences start repeatedly for as long as the synchronized trigger stays high.
- R7: In either level mode, once the trigger goes inactive, the sequence in progress completes and no further sequence starts.
- R8: In an edge mode, an active edge seen while busy, other than in the done cycle, sets `trig_ovr` and starts no sequence, either at once or later.
- R9: `trig_ovr` stays set until `ovr_clr` is 1. If a clear and a new overrun fall in the same cycle, the flag stays set.
- R10: After reset the trigger source is input NCH-1. A `src_ld` pulse loads `src_din` as the new source index, and activity on inputs that are not selected has no effect.
- R11: `busy` (the converter clock enable) rises in the cycle after `seq_start` and falls after `seq_done` unless a new start coincides. For a single sequence it stays high for exactly the engine latency in cycles. After reset, `busy`, `seq_start` and `trig_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trig_en | input | 1 | 1: external trigger controls starts |
| cfg_level | input | 1 | 1: level sensing, 0: edge sensing |
| cfg_pol | input | 1 | 1: rising/high active, 0: falling/low active |
| cfg_scan | input | 1 | Software mode: 1 continuous, 0 single |
| src_ld | input | 1 | Load strobe for trigger source index |
| src_din | input | SEL_W | New trigger source index |
| sw_start | input | 1 | Software start pulse |
| trig_in | input | NCH | Candidate trigger inputs (asynchronous) |
| seq_done | input | 1 | One-cycle done pulse from conversion engine |
| ovr_clr | input | 1 | Write-1 clear of overrun flag |
| seq_start | output | 1 | One-cycle sequence start pulse |
| busy | output | 1 | Sequence in progress; converter clock enable |
| trig_ovr | output | 1 | Sticky trigger overrun flag |

## Verification
The bench builds the block with NCH=16, so the reset source index is 15 and SEL_W is 4. This lets it show that the reset default is an index other than 0 before it moves the source to input 3. The bench's engine model has a latency of 6 cycles. A short latency like this fits several level-mode and continuous sequences into short windows. It is also long enough that a second edge, delayed by the two-cycle synchronizer, can land mid-sequence to provoke an overrun.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [2:0] {
    M_SINGLE = 3'd0,
    M_CONT   = 3'd1,
    M_FALL   = 3'd2,
    M_RISE   = 3'd3,
    M_LOW    = 3'd4,
    M_HIGH   = 3'd5
  } trig_mode_e;

  // Map the four control bits onto one of six behaviours.
  function automatic trig_mode_e decode_mode(input logic te, input logic lvl,
                                             input logic pol, input logic scan);
    trig_mode_e m;
    if (!te)      m = scan ? M_CONT : M_SINGLE;
    else if (lvl) m = pol ? M_HIGH : M_LOW;
    else          m = pol ? M_RISE : M_FALL;
    return m;
  endfunction

  // Active edge of the sampled trigger for the given polarity.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic logic is_edge_mode(input trig_mode_e m);
    return (m == M_FALL) || (m == M_RISE);
  endfunction

  function automatic logic is_level_mode(input trig_mode_e m);
    return (m == M_LOW) || (m == M_HIGH);
  endfunction

endpackage

// File: rtl/trig_input_sync.sv
module trig_input_sync
  import adc_trig_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int SEL_W  = $clog2(NCH),
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   trig_in,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             pol,
  output logic             trig_edge,
  output logic             trig_lvl_act
);
  logic            raw_sel;
  logic [STAGES:0] chain_q;   // STAGES sync flops plus one history flop

  assign raw_sel = trig_in[src_sel];

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= raw_sel;
      else             chain_q[g] <= chain_q[g-1];
    end
  end

  assign trig_edge    = edge_hit(chain_q[STAGES-1], chain_q[STAGES], pol);
  assign trig_lvl_act = (chain_q[STAGES-1] == pol);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       sw_start,
  input  logic       trig_edge,
  input  logic       trig_lvl_act,
  input  logic       seq_done,
  output logic       seq_start,
  output logic       busy,
  output logic       ovr_event
);
  logic busy_q;
  logic sw_run_q;
  logic start_req;
  logic start_ok;

  always_comb begin
    unique case (mode)
      M_SINGLE:      start_req = sw_start;
      M_CONT:        start_req = sw_start | sw_run_q;
      M_FALL, M_RISE: start_req = trig_edge;
      M_LOW, M_HIGH: start_req = trig_lvl_act;
      default:       start_req = 1'b0;
    endcase
  end

  // A new sequence may begin when idle or in the done cycle of the last one.
  assign start_ok  = ~busy_q | seq_done;
  assign seq_start = start_req & start_ok;
  assign ovr_event = is_edge_mode(mode) & trig_edge & busy_q & ~seq_done;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sw_run_q <= 1'b0;
    end else begin
      if (seq_start)     busy_q <= 1'b1;
      else if (seq_done) busy_q <= 1'b0;

      if (mode != M_CONT) sw_run_q <= 1'b0;
      else if (sw_start)  sw_run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ovr_flag.sv
module ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;   // a new overrun beats a clear
    else if (clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int SEL_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_trig_en,
  input  logic             cfg_level,
  input  logic             cfg_pol,
  input  logic             cfg_scan,
  input  logic             src_ld,
  input  logic [SEL_W-1:0] src_din,
  input  logic             sw_start,
  input  logic [NCH-1:0]   trig_in,
  input  logic             seq_done,
  input  logic             ovr_clr,
  output logic             seq_start,
  output logic             busy,
  output logic             trig_ovr
);
  localparam logic [SEL_W-1:0] SRC_RST = SEL_W'(NCH - 1);

  trig_mode_e       mode;
  logic [SEL_W-1:0] src_q;
  logic             trig_edge;
  logic             trig_lvl_act;
  logic             ovr_event;

  assign mode = decode_mode(cfg_trig_en, cfg_level, cfg_pol, cfg_scan);

  always_ff @(posedge clk) begin
    if (!rst_n)      src_q <= SRC_RST;
    else if (src_ld) src_q <= src_din;
  end

  trig_input_sync #(.NCH(NCH), .SEL_W(SEL_W), .STAGES(2)) sync_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_in      (trig_in),
    .src_sel      (src_q),
    .pol          (cfg_pol),
    .trig_edge    (trig_edge),
    .trig_lvl_act (trig_lvl_act)
  );

  seq_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .sw_start     (sw_start),
    .trig_edge    (trig_edge),
    .trig_lvl_act (trig_lvl_act),
    .seq_done     (seq_done),
    .seq_start    (seq_start),
    .busy         (busy),
    .ovr_event    (ovr_event)
  );

  ovr_flag ovr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (ovr_event),
    .clr    (ovr_clr),
    .flag   (trig_ovr)
  );
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk
  import adc_trig_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input trig_mode_e mode,
  input logic       sw_start,
  input logic       trig_edge,
  input logic       trig_lvl_act,
  input logic       seq_done,
  input logic       ovr_clr,
  input logic       ovr_event,
  input logic       seq_start,
  input logic       busy,
  input logic       trig_ovr
);
  p_start_when_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (!busy || seq_done));

  p_busy_follows_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> busy);

  p_busy_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seq_done && !seq_start) |=> !busy);

  p_single_needs_sw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SINGLE && seq_start) |-> sw_start);

  p_edge_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge_mode(mode) && seq_start) |-> trig_edge);

  p_level_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_level_mode(mode) && seq_start) |-> trig_lvl_act);

  p_ovr_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |-> !seq_start);

  p_ovr_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_ovr) |-> $past(busy));

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ovr && !ovr_clr) |=> trig_ovr);

  p_ovr_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_event && ovr_clr) |=> trig_ovr);
endmodule

bind adc_trig_seq adc_trig_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .sw_start     (sw_start),
  .trig_edge    (trig_edge),
  .trig_lvl_act (trig_lvl_act),
  .seq_done     (seq_done),
  .ovr_clr      (ovr_clr),
  .ovr_event    (ovr_event),
  .seq_start    (seq_start),
  .busy         (busy),
  .trig_ovr     (trig_ovr)
);

// File: tb/adc_trig_seq_tb_top.sv
module adc_trig_seq_tb_top;
  localparam int NCH   = 16;
  localparam int SEL_W = 4;
  localparam int LAT   = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_trig_en = 1'b0, cfg_level = 1'b0, cfg_pol = 1'b0, cfg_scan = 1'b0;
  logic             src_ld = 1'b0;
  logic [SEL_W-1:0] src_din = '0;
  logic             sw_start = 1'b0;
  logic [NCH-1:0]   trig_in = '0;
  logic             seq_done;
  logic             ovr_clr = 1'b0;
  logic             seq_start, busy, trig_ovr;

  int n_total = 0, n_fail = 0;
  int n_start = 0, n_busy = 0;
  int eng_cnt = 0;
  logic saw_ovr = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  adc_trig_seq #(.NCH(NCH), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_trig_en(cfg_trig_en), .cfg_level(cfg_level),
    .cfg_pol(cfg_pol), .cfg_scan(cfg_scan), .src_ld(src_ld), .src_din(src_din),
    .sw_start(sw_start), .trig_in(trig_in), .seq_done(seq_done), .ovr_clr(ovr_clr),
    .seq_start(seq_start), .busy(busy), .trig_ovr(trig_ovr)
  );

  // Fixed-latency conversion engine model.
  always @(posedge clk) begin
    if (!rst_n)         eng_cnt <= 0;
    else if (seq_start) eng_cnt <= LAT;
    else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
  end
  assign seq_done = (eng_cnt == 1);

  always @(posedge clk) if (rst_n && seq_start) n_start <= n_start + 1;
  always @(negedge clk) begin
    if (busy) n_busy <= n_busy + 1;
    if (trig_ovr) saw_ovr <= 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw();
    sw_start = 1'b1; cyc(1); sw_start = 1'b0;
  endtask

  task automatic set_mode(input logic te, input logic lv, input logic po, input logic sc);
    cfg_trig_en = te; cfg_level = lv; cfg_pol = po; cfg_scan = sc;
  endtask

  task automatic t_reset();
    chk("R11 busy after reset", busy, 0);
    chk("R11 ovr after reset", trig_ovr, 0);
    chk("R11 no start after reset", n_start, 0);
  endtask

  task automatic t_single();
    int s0 = n_start, b0 = n_busy;
    set_mode(0, 0, 0, 0); cyc(3);
    pulse_sw(); cyc(2);
    pulse_sw();                       // ignored while busy
    for (int i = 0; i < 4; i++) begin trig_in[15] = ~trig_in[15]; cyc(3); end
    cyc(10);
    chk("R1 single start count", n_start - s0, 1);
    chk("R11 busy cycles per sequence", n_busy - b0, LAT);
    chk("R1 idle after single", busy, 0);
  endtask

  task automatic t_cont();
    int s0 = n_start, s1;
    set_mode(0, 0, 0, 1);
    pulse_sw(); cyc(40);
    chk("R2 repeated sequences", (n_start - s0) >= 5, 1);
    chk("R2 busy while scanning", busy, 1);
    cfg_scan = 1'b0; cyc(LAT + 2);
    s1 = n_start; cyc(20);
    chk("R2 stop after scan cleared", n_start - s1, 0);
    chk("R2 idle after stop", busy, 0);
  endtask

  task automatic t_edge(input logic pol, input int ch, input string req);
    int s0;
    trig_in[ch] = ~pol; cyc(5);
    set_mode(1, 0, pol, 0); cyc(3);
    s0 = n_start;
    for (int i = 0; i < 3; i++) begin
      trig_in[ch] = pol; cyc(3); trig_in[ch] = ~pol; cyc(12);
    end
    chk(req, n_start - s0, 3);
    chk({req, " no overrun"}, trig_ovr, 0);
  endtask

  task automatic t_src();
    int s0;
    set_mode(1, 0, 1, 0);
    trig_in = '0; cyc(5);
    src_din = 4'd3; src_ld = 1'b1; cyc(1); src_ld = 1'b0; cyc(4);
    s0 = n_start;
    for (int i = 0; i < 2; i++) begin trig_in[15] = 1'b1; cyc(3); trig_in[15] = 1'b0; cyc(12); end
    chk("R10 deselected input ignored", n_start - s0, 0);
    trig_in[3] = 1'b1; cyc(3); trig_in[3] = 1'b0; cyc(12);
    chk("R10 newly selected input starts", n_start - s0, 1);
  endtask

  task automatic t_level(input logic pol, input string req);
    int s0, s1;
    trig_in[3] = ~pol; cyc(5);
    set_mode(1, 1, pol, 0); cyc(5);
    s0 = n_start;
    chk({req, " inactive level idle"}, n_start - s0 + busy, 0);
    trig_in[3] = pol; cyc(30);
    chk(req, (n_start - s0) >= 3, 1);
    chk({req, " busy while active"}, busy, 1);
    trig_in[3] = ~pol; cyc(LAT + 6);
    chk("R7 sequence completes on release", busy, 0);
    s1 = n_start; cyc(20);
    chk("R7 no start after release", n_start - s1, 0);
  endtask

  task automatic double_edge();
    trig_in[3] = 1'b1; cyc(3); trig_in[3] = 1'b0; cyc(1); trig_in[3] = 1'b1; cyc(2);
    trig_in[3] = 1'b0; cyc(15);
  endtask

  task automatic t_ovr();
    int s0;
    set_mode(1, 0, 1, 0); trig_in[3] = 1'b0; cyc(5);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    chk("R9 clear to zero", trig_ovr, 0);
    s0 = n_start;
    double_edge();
    chk("R8 overrun flagged", trig_ovr, 1);
    chk("R8 no extra start", n_start - s0, 1);
    cyc(20);
    chk("R9 flag sticky", trig_ovr, 1);
    ovr_clr = 1'b1; cyc(1); ovr_clr = 1'b0;
    chk("R9 write-1 clears", trig_ovr, 0);
    saw_ovr = 1'b0;
    ovr_clr = 1'b1;
    double_edge();
    ovr_clr = 1'b0; cyc(1);
    chk("R9 set wins over clear", saw_ovr, 1);
    chk("R9 clear after collision", trig_ovr, 0);
  endtask

  initial begin
    cyc(4); rst_n = 1'b1; cyc(3);
    t_reset();
    t_single();
    t_cont();
    t_edge(1'b0, 15, "R3 falling edge starts");   // reset source is 15 (R10)
    t_edge(1'b1, 15, "R4 rising edge starts");
    t_src();
    t_level(1'b0, "R5 level low repeats");
    t_level(1'b1, "R6 level high repeats");
    t_ovr();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule